// File: doc/BRIEF.md
# Framed Serial Transmit Engine

This block turns bytes from a host into asynchronous serial frames on one output line. The host drops a byte into a one-entry holding register with a write strobe, which clears the "holding register empty" flag. On the next bit-period strobe the engine copies the byte into its shift register and raises the empty flag again, so the host can queue the following byte while the current frame is on the line.

Each frame is a low start bit, then seven or eight data bits with the least significant bit first, then an optional extra bit, then one or two high stop bits. The extra bit can be even parity, odd parity or a host-supplied multiprocessor marker. The format is taken at the moment a frame is loaded.

During the last stop bit the engine either chains straight into the next frame, if a byte is waiting, or finishes and raises a "transmission done" flag. In that case the line stays high. The bit rate comes from an external one-cycle enable pulse that fires once per bit period. Two interrupt requests follow the two flags, each gated by its own enable.

Top module: `serialTxEngine`

## Requirements
- R1: After reset, `txOut` is 1, `emptyFlag` is 1, `endFlag` is 1 and no frame is in progress.
- R2: While `emptyFlag` is 0 and the engine is idle, the next cycle with `bitTick` high loads the holding register into the shift register. In the same cycle `emptyFlag` returns to 1. This happens no more than `TICK_DIV` cycles after the write when ticks come every `TICK_DIV` cycles.
- R3: A frame is sent as a 0 start bit, then the data bits LSB first, then the optional bit, then the stop bits of 1. Each bit lasts exactly one `bitTick` period, and `txOut` only changes on a clock edge where `bitTick` is high.
- R4: `cfgShortData`=1 sends 7 data bits (bits 6:0), and 0 sends 8. `cfgSlot` selects the optional bit: 0 none, 1 even parity, 2 odd parity, 3 multiprocessor bit. Parity covers only the data bits sent. Even parity makes the total number of ones, including the parity bit, even. `cfgTwoStop`=1 sends two stop bits, and 0 sends one.
- R5: In mode 3 the optional bit equals `mpBitIn` as sampled in the load cycle.
- R6: If `emptyFlag` is 0 when the last stop bit ends, the next start bit follows with no idle bit period in between.
- R7: If `emptyFlag` is 1 when the last stop bit ends, `endFlag` becomes 1, the engine goes idle and `txOut` stays 1 until the next start bit.
- R8: A host write (`hostLoad`=1) clears both `endFlag` and `emptyFlag` at the next clock edge.
- R9: `irqEmpty` is high exactly while `emptyFlag` and `ieEmpty` are both 1. `irqEnd` is high exactly while `endFlag` and `ieEnd` are both 1.
- R10: Changing `cfgShortData`, `cfgSlot` or `cfgTwoStop` during a frame does not change that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| bitTick | input | 1 | One-cycle enable, once per bit period |
| hostLoad | input | 1 | Host write strobe for the holding register |
| hostData | input | 8 | Byte written by the host |
| mpBitIn | input | 1 | Multiprocessor bit value, sampled at load |
| cfgShortData | input | 1 | 1 = seven data bits, 0 = eight |
| cfgSlot | input | 2 | Optional bit: 0 none, 1 even, 2 odd, 3 multiprocessor |
| cfgTwoStop | input | 1 | 1 = two stop bits |
| ieEmpty | input | 1 | Enable for the empty interrupt request |
| ieEnd | input | 1 | Enable for the done interrupt request |
| txOut | output | 1 | Serial line, high when idle |
| emptyFlag | output | 1 | Holding register may be written |
| endFlag | output | 1 | Last frame finished and line idle |
| irqEmpty | output | 1 | Empty interrupt request |
| irqEnd | output | 1 | Done interrupt request |

## Verification
The assertions assume that `bitTick` is a single-cycle pulse and that the host writes only while `emptyFlag` is 1. They also assume that the format inputs do not change between a write and its load. The stimulus waits for `emptyFlag` before every write and changes the format only once the engine is idle, or on purpose right after a load to exercise R10. Ticks come from a fixed divider, and writes land at random offsets, which covers both idle starts and chained frames.

// File: rtl/serTxPkg.sv
package serTxPkg;
  typedef enum logic [1:0] {
    SLOT_NONE = 2'd0,
    SLOT_EVEN = 2'd1,
    SLOT_ODD  = 2'd2,
    SLOT_MP   = 2'd3
  } slotMode_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;   // copy holding register into shift register, start bit out
    logic shift;  // advance to the next bit of the frame
    logic stop;   // frame done, return line to marking
  } txStrobe_t;
endpackage

// File: rtl/serTxCtrl.sv
module serTxCtrl
  import serTxPkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             bitTick,
  input  logic             hostLoad,
  input  logic [CNT_W-1:0] frameLen,
  output txStrobe_t        stb,
  output logic             busy,
  output logic             emptyFlag,
  output logic             endFlag
);
  logic [CNT_W-1:0] bitIdx;
  logic             lastBit;

  assign lastBit = busy && (bitIdx == frameLen - CNT_W'(1));

  always_comb begin
    stb.load  = bitTick && !emptyFlag && (!busy || lastBit);
    stb.shift = bitTick && busy && !lastBit;
    stb.stop  = bitTick && lastBit && emptyFlag;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy      <= 1'b0;
      bitIdx    <= '0;
      emptyFlag <= 1'b1;
      endFlag   <= 1'b1;
    end else begin
      if (stb.load) begin
        busy   <= 1'b1;
        bitIdx <= '0;
      end else if (stb.stop) begin
        busy   <= 1'b0;
        bitIdx <= '0;
      end else if (stb.shift) begin
        bitIdx <= bitIdx + CNT_W'(1);
      end

      if (hostLoad)      emptyFlag <= 1'b0;
      else if (stb.load) emptyFlag <= 1'b1;

      if (hostLoad)      endFlag <= 1'b0;
      else if (stb.stop) endFlag <= 1'b1;
    end
  end

  AST_LOAD_SETS_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    (stb.load && !hostLoad) |=> emptyFlag); // R2
  AST_EMPTY_RISES_ON_TICK: assert property (@(posedge clk) disable iff (!rstN)
    $rose(emptyFlag) |-> $past(bitTick)); // R2
  AST_WRITE_CLEARS_END: assert property (@(posedge clk) disable iff (!rstN)
    hostLoad |=> !endFlag); // R8
  AST_END_MEANS_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    endFlag |-> !busy); // R7
endmodule

// File: rtl/serTxDatapath.sv
module serTxDatapath
  import serTxPkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int FRAME_W = DATA_W + 4,
  parameter int CNT_W   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bitTick,
  input  txStrobe_t         stb,
  input  logic              busy,
  input  logic              hostLoad,
  input  logic [DATA_W-1:0] hostData,
  input  logic              mpBitIn,
  input  logic              cfgShortData,
  input  slotMode_t         cfgSlot,
  input  logic              cfgTwoStop,
  output logic              txOut,
  output logic [CNT_W-1:0]  frameLen
);
  localparam int FIDX_W = $clog2(FRAME_W);

  logic [DATA_W-1:0]  holdReg;
  logic [FRAME_W-2:0] shiftReg;
  logic [FRAME_W-1:0] frameNext;
  logic [CNT_W-1:0]   lenNext;
  logic               txReg;
  logic               parityBit;
  logic               slotBit;
  logic               hasSlot;
  int                 dataBits;

  // frame assembly from the holding register and the current format
  always_comb begin
    dataBits  = cfgShortData ? DATA_W - 1 : DATA_W;
    parityBit = 1'b0;
    for (int k = 0; k < DATA_W; k++)
      if (k < dataBits) parityBit = parityBit ^ holdReg[k];
    hasSlot = (cfgSlot != SLOT_NONE);
    case (cfgSlot)
      SLOT_EVEN: slotBit = parityBit;
      SLOT_ODD:  slotBit = ~parityBit;
      SLOT_MP:   slotBit = mpBitIn;
      default:   slotBit = 1'b1;
    endcase
    frameNext    = '1;
    frameNext[0] = 1'b0;
    for (int k = 0; k < DATA_W; k++)
      frameNext[k+1] = (k < dataBits) ? holdReg[k] : 1'b1;
    if (hasSlot) frameNext[FIDX_W'(dataBits + 1)] = slotBit;
    lenNext = CNT_W'(1 + dataBits + (hasSlot ? 1 : 0) + (cfgTwoStop ? 2 : 1));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdReg  <= '0;
      shiftReg <= '1;
      txReg    <= 1'b1;
      frameLen <= '0;
    end else begin
      if (hostLoad) holdReg <= hostData;
      if (stb.load) begin
        shiftReg <= frameNext[FRAME_W-1:1];
        txReg    <= frameNext[0];
        frameLen <= lenNext;
      end else if (stb.shift) begin
        shiftReg <= {1'b1, shiftReg[FRAME_W-2:1]};
        txReg    <= shiftReg[0];
      end else if (stb.stop) begin
        txReg <= 1'b1;
      end
    end
  end

  assign txOut = txReg;

  AST_IDLE_MARKS: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> txOut); // R7
  AST_HOLD_BETWEEN_TICKS: assert property (@(posedge clk) disable iff (!rstN)
    !bitTick |=> $stable(txOut)); // R3
endmodule

// File: rtl/serialTxEngine.sv
module serialTxEngine
  import serTxPkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bitTick,
  input  logic              hostLoad,
  input  logic [DATA_W-1:0] hostData,
  input  logic              mpBitIn,
  input  logic              cfgShortData,
  input  logic [1:0]        cfgSlot,
  input  logic              cfgTwoStop,
  input  logic              ieEmpty,
  input  logic              ieEnd,
  output logic              txOut,
  output logic              emptyFlag,
  output logic              endFlag,
  output logic              irqEmpty,
  output logic              irqEnd
);
  localparam int FRAME_W = DATA_W + 4;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  txStrobe_t        stb;
  logic             busy;
  logic [CNT_W-1:0] frameLen;

  serTxCtrl #(.CNT_W(CNT_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .bitTick(bitTick), .hostLoad(hostLoad),
    .frameLen(frameLen), .stb(stb), .busy(busy),
    .emptyFlag(emptyFlag), .endFlag(endFlag)
  );

  serTxDatapath #(.DATA_W(DATA_W), .FRAME_W(FRAME_W), .CNT_W(CNT_W)) i_dp (
    .clk(clk), .rstN(rstN), .bitTick(bitTick), .stb(stb), .busy(busy),
    .hostLoad(hostLoad), .hostData(hostData), .mpBitIn(mpBitIn),
    .cfgShortData(cfgShortData), .cfgSlot(slotMode_t'(cfgSlot)),
    .cfgTwoStop(cfgTwoStop), .txOut(txOut), .frameLen(frameLen)
  );

  assign irqEmpty = emptyFlag & ieEmpty;
  assign irqEnd   = endFlag & ieEnd;
endmodule

// File: tb/test_serialTxEngine.sv
module test_serialTxEngine;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 4;
  localparam int QDEPTH     = 256;
  localparam int WATCHDOG   = 150000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       bitTick = 1'b0;
  logic       hostLoad = 1'b0;
  logic [7:0] hostData = '0;
  logic       mpBitIn = 1'b0;
  logic       cfgShortData = 1'b0;
  logic [1:0] cfgSlot = 2'd0;
  logic       cfgTwoStop = 1'b0;
  logic       ieEmpty = 1'b0;
  logic       ieEnd = 1'b0;
  logic       txOut, emptyFlag, endFlag, irqEmpty, irqEnd;

  serialTxEngine i_serialTxEngine (
    .clk(clk), .rstN(rstN), .bitTick(bitTick), .hostLoad(hostLoad),
    .hostData(hostData), .mpBitIn(mpBitIn), .cfgShortData(cfgShortData),
    .cfgSlot(cfgSlot), .cfgTwoStop(cfgTwoStop), .ieEmpty(ieEmpty),
    .ieEnd(ieEnd), .txOut(txOut), .emptyFlag(emptyFlag), .endFlag(endFlag),
    .irqEmpty(irqEmpty), .irqEnd(irqEnd)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  // expected frame queue, filled at write time
  logic [11:0] expBits [QDEPTH];
  int          expLen  [QDEPTH];
  int          gapOf   [QDEPTH];
  bit          frameOk [QDEPTH];
  int          wrPtr = 0;
  int          rdPtr = 0;

  // line monitor state
  bit          inFrame = 0;
  int          bitPos = 0;
  int          gap = 0;
  int          badBits = 0;
  logic [11:0] gotBits = '1;
  int          divCnt = 0;

  function automatic void check(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endfunction

  function automatic void buildFrame(input logic [7:0] d, input bit shortD,
      input logic [1:0] slot, input bit two, input bit mp,
      output logic [11:0] bits, output int len);
    int n;
    int pos;
    bit ones;
    n = shortD ? 7 : 8;
    bits = '1;
    pos = 0;
    bits[pos] = 1'b0; pos++;
    ones = 0;
    for (int i = 0; i < n; i++) begin
      bits[pos] = d[i]; pos++;
      ones = ones ^ d[i];
    end
    if (slot == 2'd1) begin bits[pos] = ones;  pos++; end
    if (slot == 2'd2) begin bits[pos] = ~ones; pos++; end
    if (slot == 2'd3) begin bits[pos] = mp;    pos++; end
    pos = pos + (two ? 2 : 1);
    len = pos;
  endfunction

  // one sample per bit period, taken just before the tick edge
  function automatic void sampleLine();
    if (!inFrame) begin
      if (txOut == 1'b0) begin
        if (rdPtr == wrPtr) begin
          check(0, "R7 unexpected start bit on idle line", 0, 1);
        end else begin
          gapOf[rdPtr] = gap;
          gap = 0;
          gotBits = '1;
          gotBits[0] = 1'b0;
          bitPos = 1;
          badBits = 0;
          inFrame = 1;
        end
      end else begin
        gap++;
      end
    end else begin
      gotBits[bitPos] = txOut;
      if (txOut != expBits[rdPtr][bitPos]) badBits++;
      bitPos++;
      if (bitPos == expLen[rdPtr]) begin
        check(badBits == 0, "R3/R4/R5 frame bits", int'(gotBits), int'(expBits[rdPtr]));
        frameOk[rdPtr] = (badBits == 0);
        rdPtr++;
        inFrame = 0;
        gap = 0;
      end
    end
  endfunction

  always @(negedge clk) begin
    divCnt = (divCnt + 1) % TICK_DIV;
    bitTick = (divCnt == TICK_DIV - 1);
    if (bitTick && rstN) sampleLine();
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      check(0, "R3 watchdog cycles", cycles, WATCHDOG);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic writeByte(input logic [7:0] d, input bit mp);
    logic [11:0] b;
    int l;
    @(negedge clk);
    while (!emptyFlag) @(negedge clk);
    hostData = d;
    mpBitIn = mp;
    hostLoad = 1'b1;
    buildFrame(d, cfgShortData, cfgSlot, cfgTwoStop, mp, b, l);
    expBits[wrPtr] = b;
    expLen[wrPtr] = l;
    frameOk[wrPtr] = 0;
    wrPtr++;
    @(negedge clk);
    hostLoad = 1'b0;
    check(endFlag == 1'b0, "R8 end flag cleared by write", endFlag, 0);
    check(emptyFlag == 1'b0, "R8 empty flag cleared by write", emptyFlag, 0);
  endtask

  // engine idle before the write: load must follow within one tick period
  task automatic waitLoaded();
    int n = 0;
    while (!emptyFlag) begin @(negedge clk); n++; end
    check(n <= TICK_DIV, "R2 load latency", n, TICK_DIV);
    check(irqEmpty == ieEmpty, "R9 empty request after load", irqEmpty, ieEmpty);
  endtask

  task automatic drain();
    @(negedge clk);
    while (rdPtr != wrPtr || inFrame || !emptyFlag) @(negedge clk);
    repeat (2 * TICK_DIV) @(negedge clk);
    check(endFlag == 1'b1, "R7 end flag after last frame", endFlag, 1);
    check(txOut == 1'b1, "R7 line marks when idle", txOut, 1);
    check(irqEnd == ieEnd, "R9 end request follows enable", irqEnd, ieEnd);
    check(irqEmpty == ieEmpty, "R9 empty request follows enable", irqEmpty, ieEmpty);
  endtask

  initial begin
    int idx;
    void'($urandom(32'd2024));
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(txOut == 1'b1, "R1 txOut after reset", txOut, 1);
    check(emptyFlag == 1'b1, "R1 emptyFlag after reset", emptyFlag, 1);
    check(endFlag == 1'b1, "R1 endFlag after reset", endFlag, 1);
    check(irqEnd == 1'b0, "R9 irqEnd with enable off", irqEnd, 0);

    // directed formats
    ieEmpty = 1; ieEnd = 1;
    cfgShortData = 0; cfgSlot = 0; cfgTwoStop = 0;
    writeByte(8'hA5, 0); waitLoaded(); drain();
    cfgShortData = 1; cfgSlot = 1; cfgTwoStop = 0;
    writeByte(8'hFF, 0); waitLoaded(); drain();   // R4 seven bits, top bit dropped
    cfgShortData = 0; cfgSlot = 2; cfgTwoStop = 1;
    writeByte(8'h00, 0); waitLoaded(); drain();   // R4 odd parity of zero
    cfgShortData = 0; cfgSlot = 3; cfgTwoStop = 1;
    writeByte(8'h3C, 1); waitLoaded(); drain();   // R5 mp bit 1
    ieEmpty = 0; ieEnd = 0;
    writeByte(8'hC3, 0); waitLoaded(); drain();   // R5 mp bit 0, R9 enables off

    // R6 chaining: second byte queued while first is on the line
    ieEmpty = 1; ieEnd = 1;
    cfgShortData = 0; cfgSlot = 1; cfgTwoStop = 0;
    writeByte(8'h5A, 0); waitLoaded();
    idx = wrPtr;
    writeByte(8'h81, 0);
    drain();
    check(gapOf[idx] == 0, "R6 no idle bit between chained frames", gapOf[idx], 0);

    // R10 format change right after the load
    cfgShortData = 0; cfgSlot = 2; cfgTwoStop = 1;
    idx = wrPtr;
    writeByte(8'h96, 0); waitLoaded();
    cfgShortData = 1; cfgSlot = 0; cfgTwoStop = 0;
    drain();
    check(frameOk[idx] == 1, "R10 mid-frame format change ignored", frameOk[idx], 1);

    // constrained random batches
    for (int b = 0; b < 40; b++) begin
      int nb;
      cfgShortData = $urandom_range(0, 1);
      cfgSlot = 2'($urandom_range(0, 3));
      cfgTwoStop = $urandom_range(0, 1);
      ieEmpty = $urandom_range(0, 1);
      ieEnd = $urandom_range(0, 1);
      nb = $urandom_range(1, 3);
      for (int i = 0; i < nb; i++) begin
        repeat ($urandom_range(0, 20)) @(negedge clk);
        writeByte(8'($urandom_range(0, 255)), 1'($urandom_range(0, 1)));
      end
      drain();
    end

    check(rdPtr == wrPtr, "R3 all frames seen", rdPtr, wrPtr);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule